// File: doc/BRIEF.md
# Polyphase Horizontal Upscaler

This block widens one line of 8-bit samples by interpolation. Input samples come in on a valid/ready stream, with a last flag on the final sample of each line. Output samples leave on a second valid/ready stream, and the last output of each line carries its own last flag. For every output sample, a fixed-point position with ten fractional bits steps forward by a programmed increment. The integer part of that position selects which input samples feed a four-tap filter. The top three fractional bits select one of eight coefficient phases.

Software programs three things: the increment as 1024 times the input width divided by the output width, the output width minus one, and a table of eight 32-bit words. Each word holds four signed taps, and the taps of a phase are normalised to a gain of 128. An increment of zero turns the filter off and passes the stream straight through. A nonzero increment outside the supported upscale range, from 1x up to 8x, is refused. In that case an error pin is raised and neither stream handshakes.

Back-pressure rules:
- Once the output is valid, it holds its data until out_ready is seen.
- While the filter runs, an input sample is accepted only in the same cycle as the output that moves the position past an integer boundary.
- So in_ready may depend on out_ready, but out_valid never depends on out_ready.
- Configuration may change only between lines.

Top module: `upscale_h`

## Requirements
- R1: With an increment of 0, the block is a combinational pass-through: out_valid=in_valid, in_ready=out_ready, out_data=in_data, out_last=in_last.
- R2: A nonzero increment below 128 or above 1023 raises cfg_err, and keeps in_ready and out_valid low.
- R3: Output k takes its centre input index from floor(k*inc/1024) and its phase from bits 9..7 of (k*inc mod 1024).
- R4: Phase p uses the word at cfg_coef bits [32p+31:32p]. Tap t sits at bits [8t+7:8t] of that word and weights input index centre-1+t. Taps are two's complement, except that 8'h80 means +128.
- R5: The output is the weighted sum plus 64, arithmetically shifted right by 7, and clamped to the range 0..255.
- R6: Input indices below 0 use the first sample of the line. Indices past the last sample use the last sample.
- R7: A line produces exactly cfg_out_w_m1+1 output samples. out_last is high only on the final one, and out_valid stays low after it until the next line's input arrives.
- R8: After the final output, any unused input samples up to and including the one flagged in_last are consumed and discarded. The next line then starts again at position 0.
- R9: In filtering mode, an output that is valid but not accepted stays valid with unchanged data in the following cycle.
- R10: After reset, out_valid is low and cfg_err reflects only the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_inc | input | 12 | Position increment per output, in units of 1/1024 input sample; 0 selects bypass |
| cfg_out_w_m1 | input | 11 | Output line width minus one |
| cfg_coef | input | 256 | Eight phase words of four signed 8-bit taps each |
| cfg_err | output | 1 | Increment outside the supported range |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 8 | Input sample |
| in_last | input | 1 | Marks the last input sample of a line |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | 8 | Interpolated output sample |
| out_last | output | 1 | Marks the last output sample of a line |

## Verification
The hardest situation to reach is a line that supplies more input than its output width consumes. In that case the block must drain the unused tail and then restart the next line cleanly. The stimulus reaches it with a directed line whose increment is deliberately too small for its input length, followed at once by a normal line whose every output is checked. The right-edge replication is also awkward to reach, since it only shows for very short lines. Single-sample and two-sample lines at up to 8x expansion are therefore forced, alongside random line lengths, random coefficient tables and random valid/ready gaps.

// File: rtl/upscale_pkg.sv
package upscale_pkg;
  localparam int NTAP = 4;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } ups_state_e;
endpackage

// File: rtl/upscale_fir.sv
module upscale_fir #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic [upscale_pkg::NTAP*DW-1:0] win,
  input  logic [upscale_pkg::NTAP*CW-1:0] coef,
  output logic [DW-1:0]                    y
);
  localparam int NT = upscale_pkg::NTAP;
  localparam int PW = DW + CW + 2;
  localparam int SW = PW + $clog2(NT);
  localparam int SH = CW - 1;

  logic signed [PW-1:0] prod [NT];

  for (genvar t = 0; t < NT; t++) begin : g_tap
    logic [CW-1:0]        raw;
    logic signed [CW:0]   cval;
    logic signed [DW:0]   sval;
    assign raw  = coef[t*CW +: CW];
    // the most negative code stands for the unit gain (+2^(CW-1))
    assign cval = (raw == {1'b1, {(CW-1){1'b0}}}) ? $signed({2'b01, {(CW-1){1'b0}}})
                                                   : $signed({raw[CW-1], raw});
    assign sval = $signed({1'b0, win[t*DW +: DW]});
    assign prod[t] = sval * cval;
  end

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] rnd;
  always_comb begin
    acc = '0;
    for (int t = 0; t < NT; t++) acc = acc + SW'(prod[t]);
    rnd = (acc + SW'(1 <<< (SH - 1))) >>> SH;
    if (rnd[SW-1])            y = '0;
    else if (|rnd[SW-2:DW])   y = '1;
    else                      y = rnd[DW-1:0];
  end
endmodule

// File: rtl/upscale_ctrl.sv
module upscale_ctrl #(
  parameter int DW     = 8,
  parameter int FRAC_W = 10,
  parameter int SIZE_W = 11,
  parameter int PH_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            run_en,
  input  logic [FRAC_W-1:0]               step,
  input  logic [SIZE_W-1:0]               out_w_m1,
  input  logic                            in_valid,
  input  logic [DW-1:0]                   in_data,
  input  logic                            in_last,
  output logic                            in_ready,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic                            out_last,
  output logic [PH_W-1:0]                 phase,
  output logic [upscale_pkg::NTAP*DW-1:0] win_flat
);
  import upscale_pkg::*;

  ups_state_e        st_q;
  logic [1:0]        fill_q;
  logic              ended_q;
  logic [FRAC_W-1:0] frac_q;
  logic [SIZE_W-1:0] cnt_q;
  logic [DW-1:0]     win_q [NTAP];

  logic [FRAC_W:0] pos_sum;
  logic adv, is_last, need, in_fire, out_fire;

  assign pos_sum  = {1'b0, frac_q} + {1'b0, step};
  assign adv      = pos_sum[FRAC_W];
  assign is_last  = (cnt_q == out_w_m1);
  assign need     = adv && !ended_q && !is_last;
  assign phase    = frac_q[FRAC_W-1 -: PH_W];
  assign out_last = (st_q == ST_RUN) && is_last;

  always_comb begin
    in_ready = 1'b0;
    unique case (st_q)
      ST_FILL:  in_ready = run_en;
      ST_RUN:   in_ready = run_en && need && out_ready;
      ST_DRAIN: in_ready = run_en;
      default:  in_ready = 1'b0;
    endcase
  end

  assign out_valid = run_en && (st_q == ST_RUN) && (!need || in_valid);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  for (genvar t = 0; t < NTAP; t++) begin : g_flat
    assign win_flat[t*DW +: DW] = win_q[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_FILL;
      fill_q  <= '0;
      ended_q <= 1'b0;
      frac_q  <= '0;
      cnt_q   <= '0;
      for (int t = 0; t < NTAP; t++) win_q[t] <= '0;
    end else begin
      unique case (st_q)
        ST_FILL: if (in_fire) begin
          // preload: left edge replicated, later slots overwritten as samples arrive
          if (fill_q == 2'd0) begin
            for (int t = 0; t < NTAP; t++) win_q[t] <= in_data;
          end else if (fill_q == 2'd1) begin
            win_q[2] <= in_data;
            win_q[3] <= in_data;
          end else begin
            win_q[3] <= in_data;
          end
          if (in_last || fill_q == 2'd2) begin
            st_q    <= ST_RUN;
            ended_q <= in_last;
            frac_q  <= '0;
            cnt_q   <= '0;
            fill_q  <= '0;
          end else begin
            fill_q <= fill_q + 2'd1;
          end
        end
        ST_RUN: if (out_fire) begin
          if (is_last) begin
            st_q    <= ended_q ? ST_FILL : ST_DRAIN;
            ended_q <= 1'b0;
          end else begin
            cnt_q  <= cnt_q + 1'b1;
            frac_q <= pos_sum[FRAC_W-1:0];
            if (adv) begin
              for (int t = 0; t < NTAP-1; t++) win_q[t] <= win_q[t+1];
              win_q[NTAP-1] <= ended_q ? win_q[NTAP-1] : in_data;
              if (!ended_q && in_last) ended_q <= 1'b1;
            end
          end
        end
        ST_DRAIN: if (in_fire && in_last) st_q <= ST_FILL;
        default: st_q <= ST_FILL;
      endcase
    end
  end

  // R9: a stalled output keeps its phase and window
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && out_valid && !out_ready) |=>
      (!run_en || (out_valid && $stable(phase) && $stable(win_flat))));

  // R7: output counter never passes the programmed width
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (cnt_q <= out_w_m1));

  // R7: nothing more is offered right after the final output is taken
  assert_quiet_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> !out_valid);

  // R3: each line begins at position zero, phase zero
  assert_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && (cnt_q == '0)) |-> (frac_q == '0));
endmodule

// File: rtl/upscale_h.sv
module upscale_h #(
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int PHASES = 8,
  parameter int FRAC_W = 10,
  parameter int INC_W  = 12,
  parameter int SIZE_W = 11,
  parameter int MAX_UP = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [INC_W-1:0]                      cfg_inc,
  input  logic [SIZE_W-1:0]                     cfg_out_w_m1,
  input  logic [PHASES*upscale_pkg::NTAP*CW-1:0] cfg_coef,
  output logic                                  cfg_err,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [DW-1:0]                         in_data,
  input  logic                                  in_last,
  output logic                                  out_valid,
  input  logic                                  out_ready,
  output logic [DW-1:0]                         out_data,
  output logic                                  out_last
);
  localparam int WORD_W  = upscale_pkg::NTAP * CW;
  localparam int PH_W    = $clog2(PHASES);
  localparam int UNIT    = 1 << FRAC_W;
  localparam int MIN_INC = UNIT / MAX_UP;

  logic bypass, inc_ok, run_en;
  assign bypass  = (cfg_inc == '0);
  assign inc_ok  = (cfg_inc >= INC_W'(MIN_INC)) && (cfg_inc < INC_W'(UNIT));
  assign cfg_err = !bypass && !inc_ok;
  assign run_en  = inc_ok;

  logic                            f_in_ready, f_out_valid, f_out_last;
  logic [PH_W-1:0]                 phase;
  logic [upscale_pkg::NTAP*DW-1:0] win_flat;
  logic [WORD_W-1:0]               words [PHASES];
  logic [DW-1:0]                   f_y;

  for (genvar p = 0; p < PHASES; p++) begin : g_word
    assign words[p] = cfg_coef[p*WORD_W +: WORD_W];
  end

  upscale_ctrl #(.DW(DW), .FRAC_W(FRAC_W), .SIZE_W(SIZE_W), .PH_W(PH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .step(cfg_inc[FRAC_W-1:0]), .out_w_m1(cfg_out_w_m1),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(f_in_ready),
    .out_valid(f_out_valid), .out_ready(out_ready), .out_last(f_out_last),
    .phase(phase), .win_flat(win_flat)
  );

  upscale_fir #(.DW(DW), .CW(CW)) u_fir (
    .win(win_flat), .coef(words[phase]), .y(f_y)
  );

  assign in_ready  = bypass ? out_ready : f_in_ready;
  assign out_valid = bypass ? in_valid  : f_out_valid;
  assign out_data  = bypass ? in_data   : f_y;
  assign out_last  = bypass ? in_last   : f_out_last;

  // R2: a refused configuration blocks both streams
  assert_err_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!in_ready && !out_valid));

  // R1: bypass never lets the filter path raise a request
  assert_bypass_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (!f_out_valid && !f_in_ready));
endmodule

// File: tb/upscale_h_test.sv
module upscale_h_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0]  cfg_inc = 12'd512;
  logic [10:0]  cfg_out_w_m1 = '0;
  logic [255:0] cfg_coef = '0;
  logic cfg_err, in_valid = 0, in_ready, in_last = 0, out_valid, out_ready = 0, out_last;
  logic [7:0] in_data = 0, out_data;

  upscale_h uut (
    .clk(clk), .rst_n(rst_n), .cfg_inc(cfg_inc), .cfg_out_w_m1(cfg_out_w_m1),
    .cfg_coef(cfg_coef), .cfg_err(cfg_err), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int errors = 0, checks = 0;
  int x [0:63];
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tapv(int ph, int t);
    logic [7:0] b = cfg_coef[ph*32 + t*8 +: 8];
    if (b == 8'h80) return 128;
    return int'($signed(b));
  endfunction

  function automatic int ref_px(int k, int n);
    int p = k * int'(cfg_inc);
    int i = p >> 10;
    int ph = (p >> 7) & 7;
    int s = 0;
    for (int t = 0; t < 4; t++) begin
      int idx = i - 1 + t;
      if (idx < 0) idx = 0;
      if (idx > n - 1) idx = n - 1;
      s += tapv(ph, t) * x[idx];
    end
    s = (s + 64) >>> 7;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic logic [31:0] word(int a, int b, int c, int d);
    return {8'(d), 8'(c), 8'(b), 8'(a)};
  endfunction

  // drives one line of n inputs, expects m outputs
  task automatic run_line(int n, int m, bit byp);
    int ip = 0, op = 0, guard = 0;
    bit in_fired = 0, stalled = 0;
    logic [7:0] sdata = 0;
    cfg_out_w_m1 = 11'(m - 1);
    while ((op < m || ip < n) && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (in_fired) begin in_valid = 0; ip++; end
      if (!in_valid && ip < n) in_valid = ($urandom_range(0, 3) != 0);
      in_data = (ip < n) ? 8'(x[ip]) : 8'd0;
      in_last = (ip == n - 1);
      if (ip >= n) in_valid = 0;
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (stalled && !byp) begin
        chk(out_valid && out_data == sdata, "R9", int'(out_data), int'(sdata), "stalled output held");
      end
      stalled = out_valid && !out_ready;
      sdata = out_data;
      in_fired = in_valid && in_ready;
      if (out_valid && out_ready) begin
        int e = byp ? x[ip] : ref_px(op, n);
        if (byp) chk(out_data == 8'(e) && out_last == in_last, "R1", int'(out_data), e, "bypass sample");
        else chk(out_data == 8'(e), "R3 R4 R5 R6", int'(out_data), e, $sformatf("output %0d", op));
        chk(out_last == (op == m - 1), "R7", int'(out_last), int'(op == m - 1), "last flag");
        op++;
      end
    end
    chk(guard < 20000, "R8", guard, 20000, "line completion");
    @(negedge clk);
    in_valid = 0; in_last = 0; out_ready = 1;
    repeat (3) begin
      #1;
      chk(!out_valid, "R7", int'(out_valid), 0, "no extra output");
      @(negedge clk);
    end
  endtask

  task automatic std_table();
    cfg_coef[0*32 +: 32] = word(0, 128, 0, 0);
    cfg_coef[1*32 +: 32] = word(-4, 120, 14, -2);
    cfg_coef[2*32 +: 32] = word(-7, 108, 31, -4);
    cfg_coef[3*32 +: 32] = word(-9, 92, 52, -7);
    cfg_coef[4*32 +: 32] = word(-9, 73, 73, -9);
    cfg_coef[5*32 +: 32] = word(-7, 52, 92, -9);
    cfg_coef[6*32 +: 32] = word(-4, 31, 108, -7);
    cfg_coef[7*32 +: 32] = word(-2, 14, 120, -4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R10", int'(out_valid), 0, "out_valid in reset");
    chk(!cfg_err, "R10", int'(cfg_err), 0, "cfg_err in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk(!out_valid, "R10", int'(out_valid), 0, "out_valid after reset");

    // R2: refused increments
    @(negedge clk);
    cfg_inc = 12'd1024; in_valid = 1; out_ready = 1; #1;
    chk(cfg_err && !in_ready && !out_valid, "R2", int'({cfg_err, in_ready, out_valid}), 4, "inc 1024");
    @(negedge clk);
    cfg_inc = 12'd100; #1;
    chk(cfg_err && !in_ready && !out_valid, "R2", int'({cfg_err, in_ready, out_valid}), 4, "inc 100");
    @(negedge clk);
    in_valid = 0;

    // R1: bypass
    cfg_inc = 12'd0;
    for (int i = 0; i < 10; i++) x[i] = $urandom_range(0, 255);
    run_line(10, 10, 1);

    // R3: identity table exposes the integer index
    for (int p = 0; p < 8; p++) cfg_coef[p*32 +: 32] = word(0, 128, 0, 0);
    for (int i = 0; i < 5; i++) x[i] = 10 + 40 * i;
    cfg_inc = 12'(1024 * 5 / 13);
    run_line(5, 13, 0);

    // R4: 2x with half phase
    std_table();
    for (int i = 0; i < 6; i++) x[i] = $urandom_range(0, 255);
    cfg_inc = 12'd512;
    run_line(6, 12, 0);

    // R6: one- and two-sample lines at 8x
    x[0] = 200;
    cfg_inc = 12'd128;
    run_line(1, 8, 0);
    x[0] = 0; x[1] = 255;
    run_line(2, 16, 0);

    // R5: clamping both ways
    for (int p = 0; p < 8; p++) cfg_coef[p*32 +: 32] = word(-127, 128, 128, -127);
    for (int i = 0; i < 8; i++) x[i] = (i % 2) ? 255 : 0;
    cfg_inc = 12'd300;
    run_line(8, 27, 0);

    // R8: surplus input drained, then a clean line
    std_table();
    for (int i = 0; i < 10; i++) x[i] = $urandom_range(0, 255);
    cfg_inc = 12'd200;
    run_line(10, 12, 0);
    for (int i = 0; i < 4; i++) x[i] = 50 * i + 7;
    cfg_inc = 12'd512;
    run_line(4, 8, 0);

    // random lines and tables
    for (int r = 0; r < 30; r++) begin
      int n = $urandom_range(1, 20);
      int m = $urandom_range(n + 1, 8 * n);
      for (int p = 0; p < 8; p++) cfg_coef[p*32 +: 32] = $urandom;
      if (r % 3 == 0) std_table();
      for (int i = 0; i < n; i++) x[i] = $urandom_range(0, 255);
      cfg_inc = 12'((1024 * n) / m);
      run_line(n, m, 0);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule